// File: doc/BRIEF.md
# Frequency-Ranked Pool Replacement Engine

This block picks eviction victims for every data slot of a cache at once, ranking slots by how often they are referenced rather than by recency within a set. Every slot always belongs to one of four priority pools (pool 0 lowest, pool 3 highest), and each pool is a first-in, first-out queue of slot ids. A hit from the level above sets the slot's reference bit. A miss strobe shifts the head of every pool in one step: a referenced head climbs one pool, an unreferenced head drops one pool. Only heads move, so a slot's rank changes only as misses arrive.

The cache controller reads the current victim (slot id and pool index) at any time. When it refills that slot with a new line it raises the insert strobe. The engine then takes the victim out of its pool and queues it at the tail of pool 0. Each slot that leaves its pool on a miss is reported for one cycle on a per-pool flag, so that the data side can compress the line again. A slot that stays in place keeps its current form.

Top module: `grp_repl_engine`

## Requirements
- R1: After reset every slot is in pool 0 in ascending id order, with slot 0 at the head. Pools 1 to 3 are empty, all reference bits are clear, and no recompression flag is raised.
- R2: A hit sets the reference bit of the slot on `hit_slot`. A set bit takes effect at that slot's next evaluation as a pool head.
- R3: On a miss, the head of pool p (p below 3) with its bit set moves to the tail of pool p+1 and its bit is cleared. In the next cycle `recomp_vld[p]` is 1 and `recomp_slot[p*IDW +: IDW]` holds its id.
- R4: On a miss, the head of pool p (p above 0) with its bit clear moves to the tail of pool p-1 and is flagged in the same way on bit p.
- R5: On a miss, a referenced head of pool 3 moves to the tail of pool 3 and its bit is cleared. No flag is raised for it.
- R6: On a miss, an unreferenced head of pool 0 stays at the head. No flag is raised for it.
- R7: All head moves of one miss use the heads and bits as they were before the miss, and empty pools take no part. When two slots enter one pool on the same miss, the one from the lower-numbered source pool is queued first.
- R8: `vict_slot` is the head of the lowest-numbered non-empty pool, and `vict_pool` is that pool's index.
- R9: An insert without a miss removes the current victim from its pool, queues it at the tail of pool 0 and clears its bit.
- R10: An insert in the same cycle as a miss is ignored. Only the miss moves take place.
- R11: A hit in the same cycle as a move of the same slot leaves that slot's bit set.
- R12: Slots that are not at a head never change order within their pool.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | Upper-level hit on `hit_slot` |
| hit_slot | input | IDW | Slot id that was hit |
| miss_vld | input | 1 | Cache miss strobe; moves all pool heads |
| ins_vld | input | 1 | Victim slot refilled; requeue it in pool 0 |
| vict_slot | output | IDW | Current eviction victim |
| vict_pool | output | 2 | Pool holding the victim |
| recomp_vld | output | 4 | Per source pool: a slot left that pool on the last miss |
| recomp_slot | output | 4*IDW | Per source pool: id of the slot that left |

## Verification
The bench goes after the cases at the pool edges. If the top pool is handled wrongly, a referenced head runs off the end or is falsely flagged. If the bottom pool is handled wrongly, an unreferenced head is dropped or falsely flagged. It also targets a double arrival into one pool on a single miss: a design that orders arrivals wrongly, or reads heads already updated by the same step, gives a different victim sequence later on. Further cases are an insert that collides with a miss (a design that lets it through shifts pool 0), a hit in the same cycle as a move (the bit is lost if the clear wins), and a bottom pool drained empty so that the victim must come from a higher pool.

// File: rtl/grp_pkg.sv
package grp_pkg;

  localparam int unsigned GRP_POOLS = 4;
  localparam int unsigned GRP_PW    = 2;

  typedef logic [GRP_PW-1:0] pool_idx_t;

  // Index of the lowest pool whose non-empty flag is set (0 when none).
  function automatic pool_idx_t grp_lowest_pool(input logic [GRP_POOLS-1:0] nz);
    pool_idx_t r;
    r = '0;
    for (int p = GRP_POOLS - 1; p >= 0; p--) begin
      if (nz[p]) r = pool_idx_t'(p);
    end
    return r;
  endfunction

  // Circular pointer advance modulo depth.
  function automatic int unsigned grp_wrap(input int unsigned ptr, input int unsigned step,
                                           input int unsigned depth);
    int unsigned s;
    s = ptr + step;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/grp_pool_fifo.sv
module grp_pool_fifo import grp_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDW   = 4,
  parameter bit          FILL  = 1'b0,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pop,
  input  logic           push_a,
  input  logic [IDW-1:0] data_a,
  input  logic           push_b,
  input  logic [IDW-1:0] data_b,
  output logic [IDW-1:0] head,
  output logic [CW-1:0]  cnt
);

  logic [IDW-1:0] mem [DEPTH];
  logic [PW-1:0]  rd_q, wr_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  n_push;
  logic [PW-1:0]  wr_nxt1;

  assign n_push  = CW'(push_a) + CW'(push_b);
  assign wr_nxt1 = PW'(grp_wrap(32'(wr_q), 1, DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= FILL ? IDW'(i) : '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= FILL ? CW'(DEPTH) : '0;
    end else begin
      if (push_a) mem[wr_q] <= data_a;
      if (push_b) mem[wr_nxt1] <= data_b;
      if (pop) rd_q <= PW'(grp_wrap(32'(rd_q), 1, DEPTH));
      wr_q  <= PW'(grp_wrap(32'(wr_q), 32'(n_push), DEPTH));
      cnt_q <= cnt_q + n_push - CW'(pop);
    end
  end

  assign head = mem[rd_q];
  assign cnt  = cnt_q;

  // R12: a pool never holds more slots than exist
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R8: a head is only taken from a non-empty pool
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  // R7: second arrival only together with a first one
  a_r7_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    push_b |-> push_a);

endmodule

// File: rtl/grp_ref_bits.sv
module grp_ref_bits import grp_pkg::*; #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned IDW       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hit_vld,
  input  logic [IDW-1:0]           hit_slot,
  input  logic [GRP_POOLS-1:0]     clr_vld,
  input  logic [GRP_POOLS*IDW-1:0] clr_slot,
  output logic [NUM_SLOTS-1:0]     ref_vec
);

  logic [NUM_SLOTS-1:0] ref_q, clr_m, set_m;

  always_comb begin
    clr_m = '0;
    for (int p = 0; p < GRP_POOLS; p++) begin
      if (clr_vld[p]) clr_m[clr_slot[p*IDW +: IDW]] = 1'b1;
    end
    set_m = hit_vld ? (NUM_SLOTS'(1) << hit_slot) : '0;
  end

  // clearing on a move happens first, a hit in the same cycle wins
  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= (ref_q & ~clr_m) | set_m;
  end

  assign ref_vec = ref_q;

  // R2 / R11: a hit always leaves the bit set
  a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld |=> ref_q[$past(hit_slot)]);
  // R3: a moved slot without a concurrent hit loses its bit
  a_r3_move_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld[0] && !(hit_vld && hit_slot == clr_slot[IDW-1:0]))
      |=> !ref_q[$past(clr_slot[IDW-1:0])]);

endmodule

// File: rtl/grp_move_ctrl.sv
module grp_move_ctrl import grp_pkg::*; #(
  parameter int unsigned IDW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_vld,
  input  logic                     ins_vld,
  input  logic [GRP_POOLS*IDW-1:0] head_slot,
  input  logic [GRP_POOLS-1:0]     head_nz,
  input  logic [GRP_POOLS-1:0]     head_ref,
  output logic [GRP_POOLS-1:0]     pop,
  output logic [GRP_POOLS-1:0]     push_a,
  output logic [GRP_POOLS*IDW-1:0] data_a,
  output logic [GRP_POOLS-1:0]     push_b,
  output logic [GRP_POOLS*IDW-1:0] data_b,
  output logic [GRP_POOLS-1:0]     leave,
  output pool_idx_t                vict_pool,
  output logic [IDW-1:0]           vict_slot
);

  localparam int unsigned NP = GRP_POOLS;

  logic [IDW-1:0] hd [NP];
  logic [NP-1:0]  up, dn, rot;
  logic           ins_eff;

  assign ins_eff   = ins_vld && !miss_vld;
  assign vict_pool = grp_lowest_pool(head_nz);
  assign vict_slot = hd[vict_pool];

  for (genvar p = 0; p < NP; p++) begin : g_head
    assign hd[p] = head_slot[p*IDW +: IDW];
    assign up[p] = miss_vld && head_nz[p] && head_ref[p];
    assign dn[p] = miss_vld && head_nz[p] && !head_ref[p];
    if (p == NP - 1) begin : g_top
      assign rot[p]   = up[p];
      assign leave[p] = dn[p];
    end else if (p == 0) begin : g_bot
      assign rot[p]   = 1'b0;
      assign leave[p] = up[p];
    end else begin : g_mid
      assign rot[p]   = 1'b0;
      assign leave[p] = up[p] | dn[p];
    end
    assign pop[p] = leave[p] | rot[p] | (ins_eff && (vict_pool == pool_idx_t'(p)));
  end

  // arrivals per pool, in order: from below, self rotation, from above, insert
  for (genvar q = 0; q < NP; q++) begin : g_arr
    logic           blw_v, self_v, abv_v, ins_v;
    logic [IDW-1:0] blw_d, self_d, abv_d, ins_d;
    logic           pa, pb;
    logic [IDW-1:0] da, db;

    if (q > 0) begin : g_b
      assign blw_v = up[q-1];
      assign blw_d = hd[q-1];
    end else begin : g_nb
      assign blw_v = 1'b0;
      assign blw_d = '0;
    end
    assign self_v = rot[q];
    assign self_d = hd[q];
    if (q < NP - 1) begin : g_a
      assign abv_v = dn[q+1];
      assign abv_d = hd[q+1];
    end else begin : g_na
      assign abv_v = 1'b0;
      assign abv_d = '0;
    end
    if (q == 0) begin : g_i
      assign ins_v = ins_eff;
      assign ins_d = vict_slot;
    end else begin : g_ni
      assign ins_v = 1'b0;
      assign ins_d = '0;
    end

    always_comb begin
      pa = 1'b0; pb = 1'b0; da = '0; db = '0;
      if (blw_v) begin pa = 1'b1; da = blw_d; end
      if (self_v) begin
        if (pa) begin pb = 1'b1; db = self_d; end
        else    begin pa = 1'b1; da = self_d; end
      end
      if (abv_v) begin
        if (pa) begin pb = 1'b1; db = abv_d; end
        else    begin pa = 1'b1; da = abv_d; end
      end
      if (ins_v) begin
        if (pa) begin pb = 1'b1; db = ins_d; end
        else    begin pa = 1'b1; da = ins_d; end
      end
    end

    assign push_a[q]            = pa;
    assign push_b[q]            = pb;
    assign data_a[q*IDW +: IDW] = da;
    assign data_b[q*IDW +: IDW] = db;
  end

  // R6: an unreferenced bottom head is not taken out on a miss
  a_r6_bottom_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && head_nz[0] && !head_ref[0]) |-> !pop[0]);
  // R5: a referenced top head is re-queued in its own pool, not reported
  a_r5_top_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && head_nz[NP-1] && head_ref[NP-1]) |-> (pop[NP-1] && !leave[NP-1]));
  // R10: during a miss pool 0 only receives a demoted head from pool 1
  a_r10_ins_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |-> (push_a[0] == (head_nz[1] && !head_ref[1]) && !push_b[0]));

endmodule

// File: rtl/grp_repl_engine.sv
module grp_repl_engine import grp_pkg::*; #(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned IDW      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned CW       = $clog2(NUM_SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hit_vld,
  input  logic [IDW-1:0]           hit_slot,
  input  logic                     miss_vld,
  input  logic                     ins_vld,
  output logic [IDW-1:0]           vict_slot,
  output logic [GRP_PW-1:0]        vict_pool,
  output logic [GRP_POOLS-1:0]     recomp_vld,
  output logic [GRP_POOLS*IDW-1:0] recomp_slot
);

  localparam int unsigned NP = GRP_POOLS;

  logic [NP*IDW-1:0]    head_flat, data_a, data_b;
  logic [NP-1:0]        head_nz, head_ref, pop, push_a, push_b, leave;
  logic [CW-1:0]        cnt [NP];
  logic [NUM_SLOTS-1:0] ref_vec;
  pool_idx_t            vict_pool_w;
  logic [NP-1:0]        recomp_vld_q;
  logic [NP*IDW-1:0]    recomp_slot_q;
  int unsigned          cnt_sum;

  for (genvar p = 0; p < NP; p++) begin : g_pool
    grp_pool_fifo #(
      .DEPTH (NUM_SLOTS),
      .IDW   (IDW),
      .FILL  (p == 0)
    ) i_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .pop    (pop[p]),
      .push_a (push_a[p]),
      .data_a (data_a[p*IDW +: IDW]),
      .push_b (push_b[p]),
      .data_b (data_b[p*IDW +: IDW]),
      .head   (head_flat[p*IDW +: IDW]),
      .cnt    (cnt[p])
    );
    assign head_nz[p]  = (cnt[p] != '0);
    assign head_ref[p] = ref_vec[head_flat[p*IDW +: IDW]];
  end

  grp_ref_bits #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDW       (IDW)
  ) i_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_vld  (hit_vld),
    .hit_slot (hit_slot),
    .clr_vld  (pop),
    .clr_slot (head_flat),
    .ref_vec  (ref_vec)
  );

  grp_move_ctrl #(
    .IDW (IDW)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_vld  (miss_vld),
    .ins_vld   (ins_vld),
    .head_slot (head_flat),
    .head_nz   (head_nz),
    .head_ref  (head_ref),
    .pop       (pop),
    .push_a    (push_a),
    .data_a    (data_a),
    .push_b    (push_b),
    .data_b    (data_b),
    .leave     (leave),
    .vict_pool (vict_pool_w),
    .vict_slot (vict_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recomp_vld_q  <= '0;
      recomp_slot_q <= '0;
    end else begin
      recomp_vld_q <= leave;
      for (int p = 0; p < NP; p++) begin
        recomp_slot_q[p*IDW +: IDW] <= leave[p] ? head_flat[p*IDW +: IDW] : '0;
      end
    end
  end

  assign vict_pool   = vict_pool_w;
  assign recomp_vld  = recomp_vld_q;
  assign recomp_slot = recomp_slot_q;

  always_comb begin
    cnt_sum = 0;
    for (int p = 0; p < NP; p++) cnt_sum += 32'(cnt[p]);
  end

  // R7: moves never create or lose slots
  a_r7_slots_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sum == NUM_SLOTS);
  // R8: the victim comes from a pool that holds slots
  a_r8_victim_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    head_nz[vict_pool_w]);
  // R3: recompression flags only follow a miss
  a_r3_flag_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (recomp_vld_q != '0) |-> $past(miss_vld));
  // R9: an insert from a higher pool grows pool 0 by one
  a_r9_ins_grows_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && !miss_vld && vict_pool_w != '0) |=> (cnt[0] == $past(cnt[0]) + CW'(1)));

endmodule

// File: tb/test_grp_repl_engine.sv
`timescale 1ns/1ps
module test_grp_repl_engine;

  localparam int N   = 16;
  localparam int IDW = 4;
  localparam int NP  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hit_vld = 1'b0;
  logic [IDW-1:0]   hit_slot = '0;
  logic             miss_vld = 1'b0;
  logic             ins_vld = 1'b0;
  logic [IDW-1:0]   vict_slot;
  logic [1:0]       vict_pool;
  logic [NP-1:0]    recomp_vld;
  logic [NP*IDW-1:0] recomp_slot;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int unsigned pq[NP][$];
  bit          rf[N];
  bit [NP-1:0] exp_rv;
  int          exp_rs[NP];

  always #4 clk = ~clk;

  grp_repl_engine #(.NUM_SLOTS(N)) i_grp_repl_engine (
    .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_slot(hit_slot),
    .miss_vld(miss_vld), .ins_vld(ins_vld), .vict_slot(vict_slot),
    .vict_pool(vict_pool), .recomp_vld(recomp_vld), .recomp_slot(recomp_slot)
  );

  function automatic int low_pool();
    for (int p = 0; p < NP; p++) if (pq[p].size() > 0) return p;
    return 0;
  endfunction

  // bench-side restatement of the pool rules
  function automatic void model_apply(bit h, int hs, bit m, bit ins);
    int  hd[NP];
    bit  hv[NP], hr[NP], lv[NP], rt[NP];
    exp_rv = '0;
    for (int p = 0; p < NP; p++) exp_rs[p] = 0;
    if (m) begin
      for (int p = 0; p < NP; p++) begin
        hv[p] = pq[p].size() > 0;
        hd[p] = hv[p] ? int'(pq[p][0]) : 0;
        hr[p] = hv[p] ? rf[hd[p]] : 1'b0;
        lv[p] = hv[p] && ((hr[p] && p < NP-1) || (!hr[p] && p > 0));
        rt[p] = hv[p] && hr[p] && p == NP-1;
        exp_rv[p] = lv[p];
        if (lv[p]) exp_rs[p] = hd[p];
      end
      for (int p = 0; p < NP; p++)
        if (lv[p] || rt[p]) begin
          void'(pq[p].pop_front());
          rf[hd[p]] = 1'b0;
        end
      for (int q = 0; q < NP; q++) begin
        if (q > 0 && hv[q-1] && hr[q-1]) pq[q].push_back(hd[q-1]);
        if (q == NP-1 && rt[q]) pq[q].push_back(hd[q]);
        if (q < NP-1 && hv[q+1] && !hr[q+1]) pq[q].push_back(hd[q+1]);
      end
    end else if (ins) begin
      int v, s;
      v = low_pool();
      s = int'(pq[v].pop_front());
      pq[0].push_back(s);
      rf[s] = 1'b0;
    end
    if (h) rf[hs] = 1'b1;
  endfunction

  task automatic check_outputs(string tag);
    int v, es;
    bit ok;
    v  = low_pool();
    es = int'(pq[v][0]);
    total++;
    if (int'(vict_slot) != es || int'(vict_pool) != v) begin
      bad++;
      $display("FAIL %s victim: got slot %0d pool %0d, expected slot %0d pool %0d",
               tag, vict_slot, vict_pool, es, v);
    end
    total++;
    ok = (recomp_vld == exp_rv);
    for (int p = 0; p < NP; p++)
      if (exp_rv[p] && int'(recomp_slot[p*IDW +: IDW]) != exp_rs[p]) ok = 1'b0;
    if (!ok) begin
      bad++;
      $display("FAIL %s recompress flags: got vld %b slots %h, expected vld %b slots %0d %0d %0d %0d",
               tag, recomp_vld, recomp_slot, exp_rv, exp_rs[0], exp_rs[1], exp_rs[2], exp_rs[3]);
    end
  endtask

  // called at a falling edge; applies inputs for one cycle and checks after it
  task automatic step(bit h, int hs, bit m, bit ins, string tag);
    hit_vld  = h;
    hit_slot = IDW'(hs);
    miss_vld = m;
    ins_vld  = ins;
    model_apply(h, hs, m, ins);
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, got no finish, expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s;
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      pq[0].push_back(i);
      rf[i] = 1'b0;
    end
    exp_rv = '0;
    for (int p = 0; p < NP; p++) exp_rs[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1");

    step(0, 0, 1, 0, "R6");                 // no bits set: bottom head stays
    step(1, 0, 0, 0, "R2");                 // mark slot 0
    step(0, 0, 1, 0, "R3");                 // slot 0 climbs to pool 1
    step(0, 0, 1, 0, "R4");                 // slot 0 drops back, pool 0 head stays
    step(0, 0, 0, 1, "R9");                 // refill victim
    step(0, 0, 1, 1, "R10");                // insert collides with miss

    // climb one slot to the top pool
    s = int'(pq[0][0]);
    for (int k = 0; k < 3; k++) begin
      step(1, s, 0, 0, "R2");
      step(0, 0, 1, 0, "R3");
    end
    step(1, s, 0, 0, "R2");
    step(0, 0, 1, 0, "R5");                 // referenced top head rotates
    step(0, 0, 1, 0, "R4");                 // unreferenced top head drops

    // hit during the move of the same slot
    s = int'(pq[0][0]);
    step(1, s, 0, 0, "R2");
    step(1, s, 1, 0, "R11");
    step(0, 0, 1, 0, "R11");

    // drain pool 0 so the victim comes from a higher pool
    for (int k = 0; k < 24; k++) begin
      for (int j = 0; j < N; j++) step(1, j, 0, 0, "R2");
      step(0, 0, 1, 0, "R7");
    end
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, "R8");
    step(0, 0, 0, 1, "R9");

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      bit h, m, ins;
      h   = $urandom_range(99) < 60;
      m   = $urandom_range(99) < 25;
      ins = $urandom_range(99) < 20;
      step(h, int'($urandom_range(N-1)), m, ins, "R12");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule